// File: doc/BRIEF.md
# Dual-Type Reset Controller

This block decides which kind of reset the chip is in and then steps the processor out of that reset. It has three request sources. The first is an asynchronous active-low power-on pin. The second is an asynchronous active-low manual pin, gated by a software enable bit. The third is a watchdog request that names the reset kind it wants. A power-on reset drives both domain outputs: `rst_full` resets the bus controller and the I/O ports, and `rst_part` resets the CPU and the other peripherals. A manual reset drives only `rst_part`, so the bus controller and the I/O ports keep their state.

Each pin passes through a two-flop synchronizer and then a low-time counter. A low pulse shorter than `MIN_LOW` clock cycles never reaches the sequencer. When every active source has gone away, the sequencer initializes internal state for one cycle. It then fetches the reset vector over a request/acknowledge handshake. Both reset outputs stay asserted until the acknowledge arrives. On the cycle after the acknowledge, the block loads the program counter and the status-flag initial values. On the cycle after that, it releases the CPU to run.

The sequencer uses these states. `ST_HOLD` asserts the resets while a source is active. `ST_INIT` is one cycle of internal initialization. `ST_FETCH` requests the vector. `ST_LOAD` pulses the program-counter and flag load. `ST_RUN` is normal execution. The transitions are:

- HOLD→INIT when no source is active.
- INIT→FETCH.
- FETCH→LOAD on `vec_ack`.
- LOAD→RUN.
- Any state→HOLD whenever a source is active.

Top module: `rstctl_top`

## Requirements
- R1: A qualified low on `por_pin_n` gives a power-on reset, with `rst_full` and `rst_part` both high, whatever the level of `man_pin_n`. This includes power-up with the pin held low.
- R2: A qualified low on `man_pin_n` while `por_pin_n` is high and the enable bit is 1 gives a manual reset: `rst_part` is high and `rst_full` is low.
- R3: The enable bit is written with `mre_we`/`mre_wd`, and the write is accepted only while `cpu_run` is 1. While the bit is 0, `man_pin_n` has no effect. A power-on reset clears the bit; a manual reset leaves it unchanged.
- R4: A pin is qualified only after it has been low for at least `MIN_LOW` (default 20) consecutive clock cycles. A 19-cycle low pulse causes no reset; a 20-cycle pulse causes one.
- R5: A one-cycle `wdt_req` gives a power-on reset when `wdt_type` is 0 and a manual reset when `wdt_type` is 1.
- R6: After every source has gone inactive, `vec_req` rises with `vec_addr` equal to `VEC_ADDR`. `vec_req` and the reset outputs remain high until the cycle in which `vec_ack` is sampled high.
- R7: On the cycle after the acknowledge, the following all hold at once:
  - `pc_load` is 1.
  - `pc_value` equals the `vec_data` that came with the acknowledge.
  - `flags_init` is 3'b110: bit 0 is the trace bit at 0, bit 1 is the extended interrupt mask at 1, and bit 2 is the condition-code interrupt mask at 1.
  - Both resets are low.

  On the next cycle `cpu_run` is 1.
- R8: A power-on source that arrives during a manual reset upgrades that reset to power-on. A manual source that arrives during a power-on sequence leaves `rst_full` asserted.
- R9: A new request in any state (running, initializing, fetching or loading) returns the sequencer to HOLD: `vec_req` drops on the next cycle and the resets rise.
- R10: `rst_full` is never high without `rst_part`, and at most one of `vec_req`, `pc_load` and `cpu_run` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_pin_n | input | 1 | Asynchronous power-on reset pin, active low |
| man_pin_n | input | 1 | Asynchronous manual reset pin, active low |
| mre_we | input | 1 | Write strobe for the manual-reset enable bit |
| mre_wd | input | 1 | Value written to the enable bit |
| wdt_req | input | 1 | Watchdog reset request, one-cycle pulse |
| wdt_type | input | 1 | Kind requested by the watchdog: 0 for power-on, 1 for manual |
| vec_req | output | 1 | Reset vector fetch request |
| vec_addr | output | AW | Address of the reset vector |
| vec_ack | input | 1 | Vector fetch acknowledge |
| vec_data | input | DW | Vector read data, valid with `vec_ack` |
| rst_full | output | 1 | Reset for the bus controller and the I/O ports (power-on only) |
| rst_part | output | 1 | Reset for the CPU and the other peripherals (both kinds) |
| pc_load | output | 1 | Program-counter and flag load strobe |
| pc_value | output | DW | Value loaded into the program counter |
| flags_init | output | 3 | Initial flags: {cc imask, ext imask, ext trace} |
| cpu_run | output | 1 | CPU released to execute |

## Verification
The assertions check, on every cycle, the relations that hold in every state:

- `rst_full` is covered by `rst_part`.
- Fetch, load and run are mutually exclusive.
- A fetch only occurs under reset.
- A load only follows an acknowledged fetch, and it carries the acknowledged data and the 3'b110 flag pattern.
- Run only starts after a load.

Only the bench's scenarios can show the following behaviours:

- The 19-versus-20-cycle qualification boundary.
- That a gated manual pin is ignored.
- That the enable bit survives a manual reset and is cleared by a power-on reset.
- The watchdog kind selection.
- That a power-on reset arriving during a manual reset upgrades it.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_INIT  = 3'd1,
        ST_FETCH = 3'd2,
        ST_LOAD  = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_e;

    // Encoding shared with the watchdog type input: 0 power-on, 1 manual.
    typedef enum logic {
        KIND_POR = 1'b0,
        KIND_MAN = 1'b1
    } rst_kind_e;

    localparam int FLAG_W       = 3;
    localparam int FLAG_TRACE   = 0;
    localparam int FLAG_EXT_IM  = 1;
    localparam int FLAG_CC_IM   = 2;

    function automatic logic [FLAG_W-1:0] reset_flags();
        logic [FLAG_W-1:0] f;
        f              = '0;
        f[FLAG_TRACE]  = 1'b0;
        f[FLAG_EXT_IM] = 1'b1;
        f[FLAG_CC_IM]  = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/rstctl_pinqual.sv
module rstctl_pinqual #(
    parameter int MIN_LOW = 20
) (
    input  logic clk,
    input  logic pin_n,
    output logic qual
);
    localparam int CW = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;
    localparam logic [CW-1:0] CMAX = CW'(MIN_LOW - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_cnt;
    logic          pin_s;

    assign pin_s = sync_q[1];

    always_ff @(posedge clk) begin
        sync_q <= {sync_q[0], pin_n};
    end

    // Counts consecutive low samples; restarts on any high sample.
    always_ff @(posedge clk) begin
        if (pin_s) begin
            low_cnt <= '0;
        end else if (low_cnt != CMAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qual = !pin_s && (low_cnt == CMAX);

endmodule

// File: rtl/rstctl_arb.sv
module rstctl_arb
    import rstctl_pkg::*;
(
    input  logic clk,
    input  logic por_q,
    input  logic man_q,
    input  logic wdt_req,
    input  logic wdt_type,
    input  logic mre_we,
    input  logic mre_wd,
    input  logic clr_en,
    input  logic wr_ok,
    output logic src_por,
    output logic src_man
);
    logic mre_q;
    logic wdt_por;
    logic wdt_man;

    // Enable bit: cleared only under a power-on reset, written only while running.
    always_ff @(posedge clk) begin
        if (clr_en) begin
            mre_q <= 1'b0;
        end else if (mre_we && wr_ok) begin
            mre_q <= mre_wd;
        end
    end

    assign wdt_por = wdt_req && (rst_kind_e'(wdt_type) == KIND_POR);
    assign wdt_man = wdt_req && (rst_kind_e'(wdt_type) == KIND_MAN);

    assign src_por = por_q || wdt_por;
    assign src_man = (man_q && mre_q) || wdt_man;

endmodule

// File: rtl/rstctl_seq.sv
module rstctl_seq
    import rstctl_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic              clk,
    input  logic              src_por,
    input  logic              src_man,
    input  logic              vec_ack,
    input  logic [DW-1:0]     vec_data,
    output logic              rst_full,
    output logic              rst_part,
    output logic              vec_req,
    output logic              pc_load,
    output logic [DW-1:0]     pc_value,
    output logic [FLAG_W-1:0] flags_init,
    output logic              cpu_run
);
    seq_state_e state_q, state_d;
    rst_kind_e  kind_q,  kind_d;
    logic       any_src;
    logic       in_rst;

    assign any_src = src_por || src_man;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = any_src ? ST_HOLD : ST_INIT;
            ST_INIT:  state_d = any_src ? ST_HOLD : ST_FETCH;
            ST_FETCH: begin
                if (any_src)      state_d = ST_HOLD;
                else if (vec_ack) state_d = ST_LOAD;
            end
            ST_LOAD:  state_d = any_src ? ST_HOLD : ST_RUN;
            ST_RUN:   state_d = any_src ? ST_HOLD : ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
    end

    // Kind: fresh choice from running; sticky upgrade to power-on inside a sequence.
    always_comb begin
        kind_d = kind_q;
        if (any_src) begin
            if (state_q == ST_RUN || state_q == ST_LOAD) begin
                kind_d = src_por ? KIND_POR : KIND_MAN;
            end else begin
                kind_d = (src_por || kind_q == KIND_POR) ? KIND_POR : KIND_MAN;
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
        kind_q  <= kind_d;
        if (state_q == ST_FETCH && vec_ack && !any_src) begin
            pc_value <= vec_data;
        end
    end

    assign in_rst = (state_q == ST_HOLD) || (state_q == ST_INIT) ||
                    (state_q == ST_FETCH);

    always_comb begin
        rst_part   = in_rst;
        rst_full   = in_rst && (kind_q == KIND_POR);
        vec_req    = 1'b0;
        pc_load    = 1'b0;
        flags_init = '0;
        cpu_run    = 1'b0;
        unique case (state_q)
            ST_HOLD:  ;
            ST_INIT:  ;
            ST_FETCH: vec_req = 1'b1;
            ST_LOAD: begin
                pc_load    = 1'b1;
                flags_init = reset_flags();
            end
            ST_RUN:   cpu_run = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int          MIN_LOW  = 20,
    parameter int          AW       = 24,
    parameter int          DW       = 24,
    parameter logic [AW-1:0] VEC_ADDR = '0
) (
    input  logic              clk,
    input  logic              por_pin_n,
    input  logic              man_pin_n,
    input  logic              mre_we,
    input  logic              mre_wd,
    input  logic              wdt_req,
    input  logic              wdt_type,
    output logic              vec_req,
    output logic [AW-1:0]     vec_addr,
    input  logic              vec_ack,
    input  logic [DW-1:0]     vec_data,
    output logic              rst_full,
    output logic              rst_part,
    output logic              pc_load,
    output logic [DW-1:0]     pc_value,
    output logic [FLAG_W-1:0] flags_init,
    output logic              cpu_run
);
    localparam int NPIN    = 2;
    localparam int PIN_POR = 0;
    localparam int PIN_MAN = 1;

    logic [NPIN-1:0] pins_n;
    logic [NPIN-1:0] pin_qual;
    logic            src_por;
    logic            src_man;

    assign pins_n[PIN_POR] = por_pin_n;
    assign pins_n[PIN_MAN] = man_pin_n;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        rstctl_pinqual #(.MIN_LOW(MIN_LOW)) u_qual (
            .clk   (clk),
            .pin_n (pins_n[g]),
            .qual  (pin_qual[g])
        );
    end

    rstctl_arb u_arb (
        .clk      (clk),
        .por_q    (pin_qual[PIN_POR]),
        .man_q    (pin_qual[PIN_MAN]),
        .wdt_req  (wdt_req),
        .wdt_type (wdt_type),
        .mre_we   (mre_we),
        .mre_wd   (mre_wd),
        .clr_en   (rst_full),
        .wr_ok    (cpu_run),
        .src_por  (src_por),
        .src_man  (src_man)
    );

    rstctl_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .src_por    (src_por),
        .src_man    (src_man),
        .vec_ack    (vec_ack),
        .vec_data   (vec_data),
        .rst_full   (rst_full),
        .rst_part   (rst_part),
        .vec_req    (vec_req),
        .pc_load    (pc_load),
        .pc_value   (pc_value),
        .flags_init (flags_init),
        .cpu_run    (cpu_run)
    );

    assign vec_addr = VEC_ADDR;

endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk
    import rstctl_pkg::*;
#(
    parameter int DW = 24
) (
    input logic              clk,
    input logic              vec_req,
    input logic              vec_ack,
    input logic [DW-1:0]     vec_data,
    input logic              rst_full,
    input logic              rst_part,
    input logic              pc_load,
    input logic [DW-1:0]     pc_value,
    input logic [FLAG_W-1:0] flags_init,
    input logic              cpu_run
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        armed <= armed || rst_full;
    end

    assert_full_in_part_R10: assert property (@(posedge clk) disable iff (!armed)
        rst_full |-> rst_part);

    assert_phase_excl_R10: assert property (@(posedge clk) disable iff (!armed)
        $onehot0({vec_req, pc_load, cpu_run}));

    assert_fetch_in_reset_R6: assert property (@(posedge clk) disable iff (!armed)
        vec_req |-> rst_part);

    assert_load_after_ack_R7: assert property (@(posedge clk) disable iff (!armed)
        $rose(pc_load) |-> $past(vec_req && vec_ack));

    assert_load_data_R7: assert property (@(posedge clk) disable iff (!armed)
        $rose(pc_load) |-> (pc_value == $past(vec_data)));

    assert_load_flags_R7: assert property (@(posedge clk) disable iff (!armed)
        pc_load |-> (flags_init == 3'b110 && !rst_part));

    assert_run_after_load_R7: assert property (@(posedge clk) disable iff (!armed)
        $rose(cpu_run) |-> $past(pc_load));

endmodule

bind rstctl_top rstctl_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .vec_req    (vec_req),
    .vec_ack    (vec_ack),
    .vec_data   (vec_data),
    .rst_full   (rst_full),
    .rst_part   (rst_part),
    .pc_load    (pc_load),
    .pc_value   (pc_value),
    .flags_init (flags_init),
    .cpu_run    (cpu_run)
);

// File: tb/rstctl_top_test.sv
`timescale 1ns/1ps
module rstctl_top_test;
    localparam int MIN_LOW = 20;
    localparam int AW = 24;
    localparam int DW = 24;
    localparam logic [AW-1:0] VEC = 24'h000400;

    logic clk = 1'b0;
    logic por_pin_n = 1'b0;
    logic man_pin_n = 1'b0;
    logic mre_we = 1'b0, mre_wd = 1'b0;
    logic wdt_req = 1'b0, wdt_type = 1'b0;
    logic vec_req, vec_ack = 1'b0;
    logic [AW-1:0] vec_addr;
    logic [DW-1:0] vec_data = '0, pc_value;
    logic rst_full, rst_part, pc_load, cpu_run;
    logic [2:0] flags_init;

    int n_tests = 0, n_fail = 0;
    bit saw_rst = 1'b0;
    bit mre_model = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rstctl_top #(.MIN_LOW(MIN_LOW), .AW(AW), .DW(DW), .VEC_ADDR(VEC)) uut (
        .clk, .por_pin_n, .man_pin_n, .mre_we, .mre_wd, .wdt_req, .wdt_type,
        .vec_req, .vec_addr, .vec_ack, .vec_data, .rst_full, .rst_part,
        .pc_load, .pc_value, .flags_init, .cpu_run);

    always @(negedge clk) if (rst_part) saw_rst = 1'b1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected kind: 0 none, 1 power-on, 2 manual. src: 0 por pin, 1 man pin, 2 watchdog
    function automatic int exp_kind(int src, int len, bit mre, bit wtype);
        if (src == 0) return (len >= MIN_LOW) ? 1 : 0;
        if (src == 1) return (len >= MIN_LOW && mre) ? 2 : 0;
        return wtype ? 2 : 1;
    endfunction

    task automatic pulse_pin(int which, int n);
        @(negedge clk);
        if (which == 0) por_pin_n = 1'b0; else man_pin_n = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        if (which == 0) por_pin_n = 1'b1; else man_pin_n = 1'b1;
    endtask

    task automatic wdt_pulse(bit t);
        @(negedge clk);
        wdt_req = 1'b1; wdt_type = t;
        @(negedge clk);
        wdt_req = 1'b0;
    endtask

    task automatic mre_write(bit v);
        @(negedge clk);
        mre_we = 1'b1; mre_wd = v;
        @(negedge clk);
        mre_we = 1'b0;
    endtask

    task automatic wait_req(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (vec_req) begin ok = 1'b1; break; end
        end
    endtask

    task automatic serve_fetch(logic [DW-1:0] d, int dly);
        check(vec_addr == VEC, "R6", "vector address", vec_addr, VEC);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check(vec_req && rst_part, "R6", "resets held while fetch pending",
                  {vec_req, rst_part}, 2'b11);
        end
        vec_ack = 1'b1; vec_data = d;
        @(negedge clk);
        vec_ack = 1'b0;
        check(pc_load, "R7", "pc_load after ack", pc_load, 1);
        check(pc_value == d, "R7", "pc_value", pc_value, d);
        check(flags_init == 3'b110, "R7", "flags_init", flags_init, 3'b110);
        check(!rst_part && !rst_full, "R7", "resets released on load",
              {rst_full, rst_part}, 0);
        @(negedge clk);
        check(cpu_run, "R7", "cpu_run after load", cpu_run, 1);
    endtask

    // Run a reset episode to completion expecting kind k (1 full, 2 part).
    task automatic finish_reset(int k, string req);
        bit ok;
        wait_req(ok);
        check(ok, req, "vec_req appears", ok, 1);
        check(rst_part == 1'b1, req, "rst_part during reset", rst_part, 1);
        check(rst_full == (k == 1), req, "rst_full selects kind", rst_full, (k == 1));
        serve_fetch(DW'($urandom), $urandom % 4);
        if (k == 1) mre_model = 1'b0;
    endtask

    task automatic expect_ignored(string req);
        repeat (30) @(negedge clk);
        check(!saw_rst && cpu_run, req, "request ignored", {saw_rst, cpu_run}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok;
        int seed;
        seed = $urandom(32'h5EED1234);

        // R1: power-up with both pins low: power-on kind regardless of manual pin
        @(negedge clk);
        check(rst_full && rst_part, "R1", "power-up reset state", {rst_full, rst_part}, 2'b11);
        repeat (30) @(negedge clk);
        por_pin_n = 1'b1;
        repeat (5) @(negedge clk);
        check(rst_full, "R1", "power-on kind with manual pin low", rst_full, 1);
        man_pin_n = 1'b1;
        finish_reset(1, "R1");

        // R3: enable is 0 after power-on, manual pin ignored
        saw_rst = 0;
        pulse_pin(1, 30);
        expect_ignored("R3");

        // R4 + R2: enable on, 19 cycles rejected, 20 accepted as manual
        mre_write(1'b1); mre_model = 1'b1;
        saw_rst = 0;
        pulse_pin(1, MIN_LOW - 1);
        expect_ignored("R4");
        pulse_pin(1, MIN_LOW);
        finish_reset(2, "R2");

        // R3: enable survives manual reset
        pulse_pin(1, 25);
        finish_reset(2, "R3");

        // R8: power-on during manual upgrades the kind
        @(negedge clk); man_pin_n = 1'b0;
        repeat (30) @(negedge clk);
        check(rst_part && !rst_full, "R8", "manual hold before upgrade", {rst_full, rst_part}, 2'b01);
        por_pin_n = 1'b0;
        repeat (25) @(negedge clk);
        check(rst_full, "R8", "upgraded to power-on", rst_full, 1);
        por_pin_n = 1'b1;
        repeat (3) @(negedge clk);
        man_pin_n = 1'b1;
        finish_reset(1, "R8");

        // R3: power-on cleared the enable, manual pin ignored again
        saw_rst = 0;
        pulse_pin(1, 30);
        expect_ignored("R3");

        // R9 + R8: manual watchdog during power-on fetch restarts, kind stays power-on
        wdt_pulse(1'b0);
        wait_req(ok);
        check(ok && rst_full, "R5", "watchdog power-on kind", rst_full, 1);
        wdt_req = 1'b1; wdt_type = 1'b1;
        @(negedge clk);
        wdt_req = 1'b0;
        check(!vec_req && rst_part, "R9", "request mid-fetch returns to hold",
              {vec_req, rst_part}, 2'b01);
        finish_reset(1, "R8");

        // R4: power-on pin boundary
        saw_rst = 0;
        pulse_pin(0, MIN_LOW - 1);
        expect_ignored("R4");
        pulse_pin(0, MIN_LOW);
        finish_reset(1, "R4");

        // R5: watchdog manual kind
        wdt_pulse(1'b1);
        finish_reset(2, "R5");

        // R9: request during load
        wdt_pulse(1'b1);
        wait_req(ok);
        vec_ack = 1'b1; vec_data = 24'h00ABCD;
        @(negedge clk);
        vec_ack = 1'b0;
        wdt_req = 1'b1; wdt_type = 1'b1;
        @(negedge clk);
        wdt_req = 1'b0;
        check(rst_part && !cpu_run, "R9", "request during load returns to hold",
              {rst_part, cpu_run}, 2'b10);
        finish_reset(2, "R9");

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int src, len, k;
            bit wt;
            bit wv;
            wv = 1'($urandom);
            mre_write(wv); mre_model = wv;
            src = $urandom % 3;
            len = 10 + ($urandom % 26);
            wt = 1'($urandom);
            k = exp_kind(src, len, mre_model, wt);
            saw_rst = 0;
            if (src == 2) wdt_pulse(wt);
            else pulse_pin(src, len);
            if (k == 0) expect_ignored(src == 1 ? "R3" : "R4");
            else finish_reset(k, src == 2 ? "R5" : (src == 0 ? "R1" : "R2"));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule